// File: doc/BRIEF.md
# LIN I/O Slave Mode Sequencer

This block decides which operating mode a LIN-controlled I/O slave is in, and what follows from that mode. The modes are configuration, active, sleep, standby and limp-home. Power-on and undervoltage events always return it to configuration and clear the stored output data. A configuration-complete strobe moves it to active. In active mode the I/O pins follow the most recent output frame. A sleep command selects one of two low-power modes. A bus failure forces the limp-home pattern onto the pins. A wake-up event brings the block back to active mode with the stored data intact.

The block produces four things. The first is the source selection and value for the I/O drivers, with an enable that stands for high impedance. The second is the INH level, which can switch an external regulator. The last two are the reset lines for the PWM and ADC units.

On entry to a low-power mode, a programmed flag picks one of two behaviours: keep the last driven value, or load a preset pattern. After every wake-up, the first output frame is thrown away, because it is the frame that woke the node.

All outputs are registered. They change on the same clock edge as the mode register.

Top module: `lin_io_mode_ctrl`

## Requirements
- R1: After `rst`, `por_evt` or `uv_evt`, the block is in configuration mode (`mode`=0) from the next edge on, and the stored output data is cleared to 0x00.
- R2: In configuration mode, `out_en`=0, `out_drive`=0, `out_sel`=0 (high impedance), `inh`=1, and `pwm_rst`=`adc_rst`=1.
- R3: Configuration mode is left only by `cfg_done`, which moves the block to active mode (`mode`=1). Output frames received in configuration mode are ignored.
- R4: In active mode:
  - `out_sel` is 1 and `out_drive` shows the data of the latest accepted frame, from the edge that sampled `rx_valid` onward.
  - `inh` is 1 when `inh_extreg`=1, and otherwise follows `inh_level`.
  - The PWM and ADC resets are released.
- R5: `sleep_cmd` in active mode enters sleep (`mode`=2) when `lp_kind`=0, or standby (`mode`=3) when `lp_kind`=1. On entry, `lp_hold`=1 keeps the last `out_drive` (`out_sel`=2), while `lp_hold`=0 loads `lp_pattern` (`out_sel`=3).
- R6: `bus_fail` in active, sleep or standby mode enters limp-home (`mode`=4), with `out_drive`=`limp_pattern` and `out_sel`=4. It takes priority over `sleep_cmd` and has no effect in configuration mode.
- R7: `pwm_rst` and `adc_rst` are held high in configuration, sleep and limp-home, and are low in active and standby.
- R8: `inh` is 0 in sleep and limp-home. In standby, `inh` equals `inh_extreg`.
- R9: `wake` in sleep, standby or limp-home returns the block to active mode, and `out_drive` resumes the stored frame data with no reload of defaults. In limp-home, `wake` is ignored while `bus_fail` is high.
- R10: The first `rx_valid` in active mode after a wake-up is discarded. Later frames are accepted.
- R11: `por_evt` and `uv_evt` override every other event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_evt | input | 1 | Power-on event pulse |
| uv_evt | input | 1 | Undervoltage event pulse |
| cfg_done | input | 1 | Configuration complete |
| sleep_cmd | input | 1 | Go-to-low-power command |
| lp_kind | input | 1 | Low-power kind: 0 sleep, 1 standby |
| lp_hold | input | 1 | 1 keeps last outputs on low-power entry, 0 loads preset |
| lp_pattern | input | OUT_W | Preset low-power output pattern |
| bus_fail | input | 1 | Bus failure indication |
| limp_pattern | input | OUT_W | Limp-home output pattern |
| wake | input | 1 | Wake-up event |
| rx_valid | input | 1 | Output-data frame received strobe |
| rx_data | input | OUT_W | Output data of the received frame |
| inh_extreg | input | 1 | INH configured to switch an external regulator |
| inh_level | input | 1 | Programmed INH level for active mode |
| mode | output | 3 | Current mode: 0 cfg, 1 active, 2 sleep, 3 standby, 4 limp |
| out_sel | output | 3 | Output source: 0 hi-Z, 1 data, 2 hold, 3 preset, 4 limp |
| out_en | output | 1 | Output drivers enabled (0 = high impedance) |
| out_drive | output | OUT_W | Output value to the pin drivers |
| inh | output | 1 | INH output level |
| pwm_rst | output | 1 | PWM unit reset |
| adc_rst | output | 1 | ADC unit reset |

## Verification
The assertions assume that event inputs are sampled as single-cycle strobes, and that the programmed settings (`lp_hold`, patterns, INH settings) are stable in the cycle they are used. The bench drives each event for exactly one cycle, at the falling edge. It changes the settings only together with the event that consumes them.

Simultaneous events are applied on purpose to exercise the priority rules:
- power-on together with configuration-complete;
- sleep together with failure;
- wake together with failure;
- wake together with a frame.

Every combination the bench uses stays inside the documented priority order.

// File: rtl/lin_iomode_pkg.sv
package lin_iomode_pkg;

  typedef enum logic [2:0] {
    M_CFG  = 3'd0,
    M_ACT  = 3'd1,
    M_SLP  = 3'd2,
    M_STB  = 3'd3,
    M_LIMP = 3'd4
  } mode_e;

  typedef enum logic [2:0] {
    S_HIZ    = 3'd0,
    S_DATA   = 3'd1,
    S_HOLD   = 3'd2,
    S_PRESET = 3'd3,
    S_LIMP   = 3'd4
  } osel_e;

  function automatic logic is_lowpwr(input mode_e m);
    return (m == M_SLP) || (m == M_STB) || (m == M_LIMP);
  endfunction

endpackage

// File: rtl/lin_iomode_fsm.sv
module lin_iomode_fsm
  import lin_iomode_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  por_evt,
  input  logic  uv_evt,
  input  logic  cfg_done,
  input  logic  sleep_cmd,
  input  logic  lp_kind,
  input  logic  bus_fail,
  input  logic  wake,
  output mode_e mode_q,
  output mode_e mode_d
);

  logic supply_evt;
  assign supply_evt = por_evt | uv_evt;

  // Next-mode decision; supply events win over everything.
  always_comb begin
    mode_d = mode_q;
    if (supply_evt) begin
      mode_d = M_CFG;
    end else begin
      case (mode_q)
        M_CFG:  if (cfg_done) mode_d = M_ACT;
        M_ACT: begin
          if (bus_fail)       mode_d = M_LIMP;
          else if (sleep_cmd) mode_d = lp_kind ? M_STB : M_SLP;
        end
        M_SLP, M_STB: begin
          if (bus_fail)  mode_d = M_LIMP;
          else if (wake) mode_d = M_ACT;
        end
        M_LIMP: if (!bus_fail && wake) mode_d = M_ACT;
        default: mode_d = M_CFG;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= M_CFG;
    else     mode_q <= mode_d;
  end

  // R1 / R11: supply events always land in configuration
  a_r1_supply_to_cfg: assert property (@(posedge clk) disable iff (rst)
    supply_evt |=> mode_q == M_CFG);

  // R3: configuration left only through cfg_done
  a_r3_cfg_exit: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_CFG && !cfg_done) |=> mode_q == M_CFG);

  // R6: failure from an operating mode goes to limp-home
  a_r6_fail_to_limp: assert property (@(posedge clk) disable iff (rst)
    (!supply_evt && bus_fail && (mode_q == M_ACT || mode_q == M_SLP || mode_q == M_STB))
      |=> mode_q == M_LIMP);

  // R9: wake from any low-power mode returns to active
  a_r9_wake_to_act: assert property (@(posedge clk) disable iff (rst)
    (!supply_evt && !bus_fail && wake && is_lowpwr(mode_q)) |=> mode_q == M_ACT);

endmodule

// File: rtl/lin_iomode_outpath.sv
module lin_iomode_outpath
  import lin_iomode_pkg::*;
#(
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  mode_e            mode_q,
  input  mode_e            mode_d,
  input  logic             rx_valid,
  input  logic [OUT_W-1:0] rx_data,
  input  logic             lp_hold,
  input  logic [OUT_W-1:0] lp_pattern,
  input  logic [OUT_W-1:0] limp_pattern,
  output logic [OUT_W-1:0] drive_q,
  output logic             en_q,
  output osel_e            sel_q
);

  localparam logic [OUT_W-1:0] ZERO = '0;

  logic [OUT_W-1:0] data_q;
  logic             drop_q;
  logic             stay_act;
  logic             accept;
  logic             woke;

  assign stay_act = (mode_q == M_ACT) && (mode_d == M_ACT);
  assign accept   = stay_act && rx_valid && !drop_q;
  assign woke     = (mode_d == M_ACT) && is_lowpwr(mode_q);

  // Stored output data and the wake-up frame discard flag
  always_ff @(posedge clk) begin
    if (rst || mode_d == M_CFG) begin
      data_q <= ZERO;
      drop_q <= 1'b0;
    end else begin
      if (accept) data_q <= rx_data;
      if (woke)                      drop_q <= 1'b1;
      else if (stay_act && rx_valid) drop_q <= 1'b0;
    end
  end

  // Registered pin value, enable and source
  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q <= ZERO;
      en_q    <= 1'b0;
      sel_q   <= S_HIZ;
    end else begin
      case (mode_d)
        M_ACT: begin
          drive_q <= accept ? rx_data : data_q;
          en_q    <= 1'b1;
          sel_q   <= S_DATA;
        end
        M_SLP, M_STB: begin
          en_q <= 1'b1;
          if (mode_q != mode_d) begin
            if (lp_hold) begin
              sel_q <= S_HOLD;
            end else begin
              drive_q <= lp_pattern;
              sel_q   <= S_PRESET;
            end
          end
        end
        M_LIMP: begin
          drive_q <= limp_pattern;
          en_q    <= 1'b1;
          sel_q   <= S_LIMP;
        end
        default: begin
          drive_q <= ZERO;
          en_q    <= 1'b0;
          sel_q   <= S_HIZ;
        end
      endcase
    end
  end

  // R2: configuration mode keeps the pins high impedance
  a_r2_cfg_hiz: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_CFG) |-> (!en_q && drive_q == ZERO));

  // R5: hold-on-entry freezes the driven value
  a_r5_hold_entry: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_ACT && (mode_d == M_SLP || mode_d == M_STB) && lp_hold)
      |=> drive_q == $past(drive_q));

  // R6: limp-home drives the limp pattern
  a_r6_limp_pattern: assert property (@(posedge clk) disable iff (rst)
    (mode_d == M_LIMP) |=> (drive_q == $past(limp_pattern) && sel_q == S_LIMP));

  // R10: the frame right after a wake-up never reaches the pins
  a_r10_drop_first: assert property (@(posedge clk) disable iff (rst)
    (stay_act && drop_q && rx_valid) |=> drive_q == $past(data_q));

endmodule

// File: rtl/lin_iomode_supply.sv
module lin_iomode_supply
  import lin_iomode_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_e mode_d,
  input  logic  inh_extreg,
  input  logic  inh_level,
  output logic  inh_q,
  output logic  pwm_rst_q,
  output logic  adc_rst_q
);

  logic inh_n;
  logic unit_rst_n;

  always_comb begin
    case (mode_d)
      M_ACT:   inh_n = inh_extreg | inh_level;
      M_STB:   inh_n = inh_extreg;
      M_SLP,
      M_LIMP:  inh_n = 1'b0;
      default: inh_n = 1'b1;
    endcase
    unit_rst_n = !(mode_d == M_ACT || mode_d == M_STB);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inh_q     <= 1'b1;
      pwm_rst_q <= 1'b1;
      adc_rst_q <= 1'b1;
    end else begin
      inh_q     <= inh_n;
      pwm_rst_q <= unit_rst_n;
      adc_rst_q <= unit_rst_n;
    end
  end

  // R7: limp-home holds both converter units in reset
  a_r7_limp_resets: assert property (@(posedge clk) disable iff (rst)
    (mode_d == M_LIMP) |=> (pwm_rst_q && adc_rst_q));

  // R8: standby and limp differ only through the regulator setting
  a_r8_stb_inh: assert property (@(posedge clk) disable iff (rst)
    (mode_d == M_STB) |=> inh_q == $past(inh_extreg));

endmodule

// File: rtl/lin_io_mode_ctrl.sv
module lin_io_mode_ctrl
  import lin_iomode_pkg::*;
#(
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             por_evt,
  input  logic             uv_evt,
  input  logic             cfg_done,
  input  logic             sleep_cmd,
  input  logic             lp_kind,
  input  logic             lp_hold,
  input  logic [OUT_W-1:0] lp_pattern,
  input  logic             bus_fail,
  input  logic [OUT_W-1:0] limp_pattern,
  input  logic             wake,
  input  logic             rx_valid,
  input  logic [OUT_W-1:0] rx_data,
  input  logic             inh_extreg,
  input  logic             inh_level,
  output logic [2:0]       mode,
  output logic [2:0]       out_sel,
  output logic             out_en,
  output logic [OUT_W-1:0] out_drive,
  output logic             inh,
  output logic             pwm_rst,
  output logic             adc_rst
);

  mode_e mode_q;
  mode_e mode_d;
  osel_e sel_q;

  lin_iomode_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .por_evt   (por_evt),
    .uv_evt    (uv_evt),
    .cfg_done  (cfg_done),
    .sleep_cmd (sleep_cmd),
    .lp_kind   (lp_kind),
    .bus_fail  (bus_fail),
    .wake      (wake),
    .mode_q    (mode_q),
    .mode_d    (mode_d)
  );

  lin_iomode_outpath #(.OUT_W(OUT_W)) u_out (
    .clk          (clk),
    .rst          (rst),
    .mode_q       (mode_q),
    .mode_d       (mode_d),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .lp_hold      (lp_hold),
    .lp_pattern   (lp_pattern),
    .limp_pattern (limp_pattern),
    .drive_q      (out_drive),
    .en_q         (out_en),
    .sel_q        (sel_q)
  );

  lin_iomode_supply u_sup (
    .clk        (clk),
    .rst        (rst),
    .mode_d     (mode_d),
    .inh_extreg (inh_extreg),
    .inh_level  (inh_level),
    .inh_q      (inh),
    .pwm_rst_q  (pwm_rst),
    .adc_rst_q  (adc_rst)
  );

  assign mode    = mode_q;
  assign out_sel = sel_q;

  // R7: the two unit resets always move together
  a_r7_resets_paired: assert property (@(posedge clk) disable iff (rst)
    pwm_rst == adc_rst);

  // R2: configuration mode keeps INH high
  a_r2_cfg_inh: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_CFG) |-> inh);

endmodule

// File: tb/lin_io_mode_ctrl_bench.sv
`timescale 1ns/1ps
module lin_io_mode_ctrl_bench;

  localparam int W  = 8;
  localparam int NV = 25;
  localparam logic [W-1:0] LP_PAT   = 8'hA5;
  localparam logic [W-1:0] LIMP_PAT = 8'h3C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic por_evt = 0, uv_evt = 0, cfg_done = 0, sleep_cmd = 0;
  logic lp_kind = 0, lp_hold = 0, bus_fail = 0, wake = 0, rx_valid = 0;
  logic inh_extreg = 1, inh_level = 0;
  logic [W-1:0] rx_data = '0;
  logic [2:0] mode, out_sel;
  logic out_en, inh, pwm_rst, adc_rst;
  logic [W-1:0] out_drive;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  lin_io_mode_ctrl #(.OUT_W(W)) u_lin_io_mode_ctrl (
    .clk(clk), .rst(rst), .por_evt(por_evt), .uv_evt(uv_evt),
    .cfg_done(cfg_done), .sleep_cmd(sleep_cmd), .lp_kind(lp_kind),
    .lp_hold(lp_hold), .lp_pattern(LP_PAT), .bus_fail(bus_fail),
    .limp_pattern(LIMP_PAT), .wake(wake), .rx_valid(rx_valid),
    .rx_data(rx_data), .inh_extreg(inh_extreg), .inh_level(inh_level),
    .mode(mode), .out_sel(out_sel), .out_en(out_en), .out_drive(out_drive),
    .inh(inh), .pwm_rst(pwm_rst), .adc_rst(adc_rst)
  );

  // {por,uv,cfg,sleep,fail,wake,rx}, rx_data, lp_kind, lp_hold, exp mode, exp drive, exp inh
  localparam logic [28:0] VEC [NV] = '{
    {7'b0000000, 8'h00, 1'b0, 1'b0, 3'd0, 8'h00, 1'b1},
    {7'b0000001, 8'h55, 1'b0, 1'b0, 3'd0, 8'h00, 1'b1},
    {7'b0010000, 8'h00, 1'b0, 1'b0, 3'd1, 8'h00, 1'b1},
    {7'b0000001, 8'h55, 1'b0, 1'b0, 3'd1, 8'h55, 1'b1},
    {7'b0000001, 8'h66, 1'b0, 1'b0, 3'd1, 8'h66, 1'b1},
    {7'b0001000, 8'h00, 1'b0, 1'b1, 3'd2, 8'h66, 1'b0},
    {7'b0000000, 8'h00, 1'b0, 1'b0, 3'd2, 8'h66, 1'b0},
    {7'b0000010, 8'h00, 1'b0, 1'b0, 3'd1, 8'h66, 1'b1},
    {7'b0000001, 8'h77, 1'b0, 1'b0, 3'd1, 8'h66, 1'b1},
    {7'b0000001, 8'h77, 1'b0, 1'b0, 3'd1, 8'h77, 1'b1},
    {7'b0001000, 8'h00, 1'b1, 1'b0, 3'd3, 8'hA5, 1'b1},
    {7'b0000100, 8'h00, 1'b0, 1'b0, 3'd4, 8'h3C, 1'b0},
    {7'b0000110, 8'h00, 1'b0, 1'b0, 3'd4, 8'h3C, 1'b0},
    {7'b0000010, 8'h00, 1'b0, 1'b0, 3'd1, 8'h77, 1'b1},
    {7'b0000001, 8'h11, 1'b0, 1'b0, 3'd1, 8'h77, 1'b1},
    {7'b0000001, 8'h11, 1'b0, 1'b0, 3'd1, 8'h11, 1'b1},
    {7'b0000100, 8'h00, 1'b0, 1'b0, 3'd4, 8'h3C, 1'b0},
    {7'b0100000, 8'h00, 1'b0, 1'b0, 3'd0, 8'h00, 1'b1},
    {7'b0000100, 8'h00, 1'b0, 1'b0, 3'd0, 8'h00, 1'b1},
    {7'b1010000, 8'h00, 1'b0, 1'b0, 3'd0, 8'h00, 1'b1},
    {7'b0010000, 8'h00, 1'b0, 1'b0, 3'd1, 8'h00, 1'b1},
    {7'b0001100, 8'h00, 1'b0, 1'b1, 3'd4, 8'h3C, 1'b0},
    {7'b0000011, 8'h44, 1'b0, 1'b0, 3'd1, 8'h00, 1'b1},
    {7'b0000001, 8'h44, 1'b0, 1'b0, 3'd1, 8'h00, 1'b1},
    {7'b0000001, 8'h44, 1'b0, 1'b0, 3'd1, 8'h44, 1'b1}
  };

  function automatic string row_tag(input int i);
    case (i)
      0:              return "R2";
      1, 2:           return "R3";
      3, 4, 24:       return "R4";
      5, 6:           return "R5";
      7, 12, 13, 22:  return "R9";
      8, 9, 14, 15, 23: return "R10";
      10:             return "R8";
      11, 16, 18, 21: return "R6";
      17, 20:         return "R1";
      default:        return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state
    check("R2 mode", mode, 0);
    check("R2 en", out_en, 0);
    check("R2 drive", out_drive, 0);
    check("R2 inh", inh, 1);
    check("R2 pwm_rst", pwm_rst, 1);
    rst = 0;

    for (int i = 0; i < NV; i++) begin
      {por_evt, uv_evt, cfg_done, sleep_cmd, bus_fail, wake, rx_valid} = VEC[i][28:22];
      rx_data = VEC[i][21:14];
      lp_kind = VEC[i][13];
      lp_hold = VEC[i][12];
      @(negedge clk);
      check({row_tag(i), " mode"},  mode,      VEC[i][11:9]);
      check({row_tag(i), " drive"}, out_drive, VEC[i][8:1]);
      check({row_tag(i), " inh"},   inh,       VEC[i][0]);
    end
    {por_evt, uv_evt, cfg_done, sleep_cmd, bus_fail, wake, rx_valid} = '0;

    // R1: reset mid-run returns configuration defaults
    rst = 1;
    @(negedge clk);
    check("R1 mode", mode, 0);
    check("R2 sel", out_sel, 0);
    check("R7 adc_rst cfg", adc_rst, 1);
    rst = 0;

    // R4: INH follows programmed level without regulator setting
    inh_extreg = 0; inh_level = 1; cfg_done = 1;
    @(negedge clk);
    cfg_done = 0;
    check("R4 inh level", inh, 1);
    check("R4 sel", out_sel, 1);
    check("R7 pwm_rst act", pwm_rst, 0);
    inh_level = 0;
    @(negedge clk);
    check("R4 inh low", inh, 0);

    // R8 / R7: standby without regulator setting
    sleep_cmd = 1; lp_kind = 1; lp_hold = 0;
    @(negedge clk);
    sleep_cmd = 0;
    check("R8 stb mode", mode, 3);
    check("R5 preset sel", out_sel, 3);
    check("R8 stb inh", inh, 0);
    check("R7 stb pwm_rst", pwm_rst, 0);

    // R6 / R7: limp-home
    bus_fail = 1;
    @(negedge clk);
    bus_fail = 0;
    check("R6 limp sel", out_sel, 4);
    check("R7 limp pwm_rst", pwm_rst, 1);
    check("R7 limp adc_rst", adc_rst, 1);
    check("R6 limp en", out_en, 1);

    // R9 then R7 sleep
    wake = 1;
    @(negedge clk);
    wake = 0;
    check("R9 wake mode", mode, 1);
    sleep_cmd = 1; lp_kind = 0; lp_hold = 1;
    @(negedge clk);
    sleep_cmd = 0;
    check("R7 sleep pwm_rst", pwm_rst, 1);
    check("R5 hold sel", out_sel, 2);

    finish_run();
  end

endmodule